// File: doc/BRIEF.md
# Monitoring Processor Pool Allocator

This block hands out slots from a fixed pool of performance-monitoring processors to connections that ask for one. Each request names a connection by its index and says whether the connection wants to start monitoring (activation) or stop it (deactivation). An activation that finds the connection already holding a slot gets that same slot back. Otherwise the lowest-numbered free slot is bound to the connection and the answer is "confirmed". When every slot is taken, the answer is "denied" and nothing changes. A deactivation releases whatever slot the connection holds and is always answered "confirmed".

Requests arrive on a valid/ready handshake. Only one request is in flight at a time. The controller is a three-state machine:
- `ST_IDLE` accepts a request and keeps ready high.
- `ST_LOOKUP` looks for an existing owner and for a free slot.
- `ST_COMMIT` updates the occupancy and owner tables and launches the response.

The transitions are:
- IDLE→LOOKUP on an accepted request.
- LOOKUP→COMMIT unconditionally.
- COMMIT→IDLE unconditionally.

The response is a one-cycle pulse with a verdict bit and a slot number.

Top module: `pm_slot_pool`

## Requirements
- R1: After reset all slots are free, `rsp_valid` is low and `req_ready` is high.
- R2: An activation from a connection holding no slot, with at least one slot free, is answered confirmed (`rsp_granted`=1) with the lowest-index free slot, which becomes bound to that connection.
- R3: An activation when all slots are occupied and the connection holds none is answered denied (`rsp_granted`=0, `rsp_slot`=0), and the occupancy and owners stay unchanged.
- R4: A deactivation from a connection holding a slot is answered confirmed with that slot number, and the slot becomes free for later activations.
- R5: A deactivation from a connection holding no slot is answered confirmed with `rsp_slot`=0 and changes no slot.
- R6: An activation from a connection that already holds a slot is answered confirmed with that existing slot, even when the pool is full, and allocates nothing new; no connection ever owns two slots.
- R7: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is then low for the next two cycles. `rsp_valid` is high for exactly one cycle, starting three edges after the accepting edge.
- R8: The bit encodings are: `req_activate`=1 means activation and 0 means deactivation; `rsp_granted`=1 means confirmed and 0 means denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request (idle) |
| req_activate | input | 1 | 1 = activation, 0 = deactivation |
| req_conn | input | ID_W (12) | Connection index of the request |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_granted | output | 1 | 1 = confirmed, 0 = denied |
| rsp_slot | output | SLOT_W (7) | Slot granted or released; 0 when none |

## Verification
The hardest situation to reach from the ports is a completely full pool. Only there do the denial path and the full-pool re-activation path become visible.

The stimulus builds a mixed occupancy with a table of requests that includes releases and re-use of freed slots. It then issues one activation for each remaining slot from fresh connection indices until all 128 are held. At that point it checks a denial, then a re-activation by an existing owner, then a release in the middle of the pool. The release must be refilled by the previously denied connection at exactly that freed index. This proves that the denial changed nothing.

// File: rtl/pool_pkg.sv
package pool_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_COMMIT = 2'd2
    } pool_state_t;
endpackage

// File: rtl/pool_first_set.sv
// Lowest-index set-bit finder.
module pool_first_set #(
    parameter int WIDTH = 128,
    parameter int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/pool_id_cam.sv
// Compares a connection index against every live owner entry.
module pool_id_cam #(
    parameter int ENTRIES = 128,
    parameter int ID_W    = 12
) (
    input  logic [ENTRIES-1:0]           live,
    input  logic [ENTRIES-1:0][ID_W-1:0] owners,
    input  logic [ID_W-1:0]              key,
    output logic [ENTRIES-1:0]           hit_vec
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = live[g] && (owners[g] == key);
    end
endmodule

// File: rtl/pm_slot_pool.sv
module pm_slot_pool
    import pool_pkg::*;
#(
    parameter int NUM_SLOTS = 128,
    parameter int ID_W      = 12,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_activate,
    input  logic [ID_W-1:0]   req_conn,
    output logic              rsp_valid,
    output logic              rsp_granted,
    output logic [SLOT_W-1:0] rsp_slot
);
    pool_state_t state, state_nx;

    logic                           act_q;
    logic [ID_W-1:0]                conn_q;
    logic                           hit_q, free_q;
    logic [SLOT_W-1:0]              hit_idx_q, free_idx_q;
    logic [NUM_SLOTS-1:0]           occ;
    logic [NUM_SLOTS-1:0][ID_W-1:0] owner;

    logic [NUM_SLOTS-1:0] hit_vec;
    logic                 hit_any, free_any;
    logic [SLOT_W-1:0]    hit_idx, free_idx;

    assign req_ready = (state == ST_IDLE);

    pool_id_cam #(.ENTRIES(NUM_SLOTS), .ID_W(ID_W)) u_cam (
        .live(occ), .owners(owner), .key(conn_q), .hit_vec(hit_vec)
    );

    pool_first_set #(.WIDTH(NUM_SLOTS), .IDX_W(SLOT_W)) u_hit_enc (
        .vec(hit_vec), .found(hit_any), .idx(hit_idx)
    );

    pool_first_set #(.WIDTH(NUM_SLOTS), .IDX_W(SLOT_W)) u_free_enc (
        .vec(~occ), .found(free_any), .idx(free_idx)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_IDLE:   state_nx = req_valid ? ST_LOOKUP : ST_IDLE;
            ST_LOOKUP: state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q       <= 1'b0;
            conn_q      <= '0;
            hit_q       <= 1'b0;
            free_q      <= 1'b0;
            hit_idx_q   <= '0;
            free_idx_q  <= '0;
            occ         <= '0;
            owner       <= '0;
            rsp_valid   <= 1'b0;
            rsp_granted <= 1'b0;
            rsp_slot    <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        act_q  <= req_activate;
                        conn_q <= req_conn;
                    end
                end
                ST_LOOKUP: begin
                    hit_q      <= hit_any;
                    hit_idx_q  <= hit_idx;
                    free_q     <= free_any;
                    free_idx_q <= free_idx;
                end
                ST_COMMIT: begin
                    rsp_valid <= 1'b1;
                    if (act_q) begin
                        if (hit_q) begin
                            rsp_granted <= 1'b1;
                            rsp_slot    <= hit_idx_q;
                        end else if (free_q) begin
                            occ[free_idx_q]   <= 1'b1;
                            owner[free_idx_q] <= conn_q;
                            rsp_granted       <= 1'b1;
                            rsp_slot          <= free_idx_q;
                        end else begin
                            rsp_granted <= 1'b0;
                            rsp_slot    <= '0;
                        end
                    end else begin
                        rsp_granted <= 1'b1;
                        if (hit_q) begin
                            occ[hit_idx_q] <= 1'b0;
                            rsp_slot       <= hit_idx_q;
                        end else begin
                            rsp_slot <= '0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R7: busy for two cycles after acceptance, response on the third
    a_r7_accept_timing: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready ##1 !req_ready ##1 rsp_valid));

    // R7: response is a single-cycle pulse
    a_r7_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R2: a confirmed activation leaves its slot occupied and owned by the requester
    a_r2_grant_binds: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_granted && act_q) |-> (occ[rsp_slot] && owner[rsp_slot] == conn_q));

    // R3: denial only when full, and the edge that issued it changed no slot
    a_r3_deny_full_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_granted) |-> ((&occ) && occ == $past(occ)));

    // R4/R5: deactivation always confirmed, never leaves its slot held by the requester
    a_r4_deact_confirmed: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !act_q) |-> (rsp_granted && !(occ[rsp_slot] && owner[rsp_slot] == conn_q)));

    // R6: no connection owns more than one slot
    a_r6_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: tb/sim_pm_slot_pool.sv
module sim_pm_slot_pool;
    localparam int ID_W   = 12;
    localparam int SLOT_W = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_activate = 1'b0;
    logic [ID_W-1:0]   req_conn = '0;
    logic              rsp_valid;
    logic              rsp_granted;
    logic [SLOT_W-1:0] rsp_slot;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    pm_slot_pool u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_activate(req_activate), .req_conn(req_conn),
        .rsp_valid(rsp_valid), .rsp_granted(rsp_granted), .rsp_slot(rsp_slot)
    );

    task automatic chk(input logic ok, input string rq, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // Called at a negedge with the block idle. Returns at a negedge, idle again.
    task automatic do_req(input logic act, input int conn, input logic eg,
                          input int es, input string rq);
        req_valid    = 1'b1;
        req_activate = act;
        req_conn     = ID_W'(conn);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R7", "ready after accept", int'(req_ready), 0);
        chk(!rsp_valid, "R7", "early rsp (1)", int'(rsp_valid), 0);
        @(negedge clk);
        chk(!req_ready, "R7", "ready in lookup", int'(req_ready), 0);
        chk(!rsp_valid, "R7", "early rsp (2)", int'(rsp_valid), 0);
        @(negedge clk);
        chk(rsp_valid, "R7", "rsp_valid", int'(rsp_valid), 1);
        chk(req_ready, "R7", "ready back", int'(req_ready), 1);
        chk(rsp_granted == eg, rq, "granted", int'(rsp_granted), int'(eg));
        chk(int'(rsp_slot) == es, rq, "slot", int'(rsp_slot), es);
    endtask

    // {activate, conn[11:0], exp_granted, exp_slot[6:0]}
    localparam int NV = 10;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 12'd5,    1'b1, 7'd0},  // R2 first slot
        {1'b1, 12'd9,    1'b1, 7'd1},  // R2 next lowest
        {1'b1, 12'd5,    1'b1, 7'd0},  // R6 existing owner
        {1'b1, 12'd300,  1'b1, 7'd2},  // R2
        {1'b0, 12'd9,    1'b1, 7'd1},  // R4 release
        {1'b0, 12'd9,    1'b1, 7'd0},  // R5 no longer holds
        {1'b1, 12'd77,   1'b1, 7'd1},  // R4 freed slot reused
        {1'b0, 12'd4000, 1'b1, 7'd0},  // R5 unknown connection
        {1'b0, 12'd5,    1'b1, 7'd0},  // R4 release slot 0
        {1'b1, 12'd6,    1'b1, 7'd0}   // R2 lowest free is 0
    };
    localparam string VTAG [NV] = '{"R2","R2","R6","R2","R4","R5","R4","R5","R4","R2"};

    initial begin
        repeat (3) @(negedge clk);
        chk(!rsp_valid, "R1", "rsp_valid in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R1", "ready after reset", int'(req_ready), 1);
        chk(!rsp_valid, "R1", "rsp_valid after reset", int'(rsp_valid), 0);

        for (int v = 0; v < NV; v++) begin
            do_req(VEC[v][20], int'(VEC[v][19:8]), VEC[v][7], int'(VEC[v][6:0]), VTAG[v]);
        end

        // Slots 0,1,2 held by 6,77,300. Fill 3..127.
        for (int i = 0; i < 125; i++) begin
            do_req(1'b1, 1000 + i, 1'b1, 3 + i, "R2");
        end
        do_req(1'b1, 2000, 1'b0, 0, "R3");    // full: denied (R8 encoding 0)
        do_req(1'b1, 300, 1'b1, 2, "R6");     // existing owner at full pool
        do_req(1'b0, 1050, 1'b1, 53, "R4");   // release middle slot
        do_req(1'b1, 2000, 1'b1, 53, "R3");   // denial changed nothing
        do_req(1'b1, 2001, 1'b0, 0, "R3");
        do_req(1'b0, 3999, 1'b1, 0, "R5");    // non-holder at full pool
        do_req(1'b1, 2002, 1'b0, 0, "R5");    // still full after that

        // Reset mid-life empties the pool.
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R1", "ready after reset 2", int'(req_ready), 1);
        do_req(1'b1, 77, 1'b1, 0, "R1");      // pool empty again
        do_req(1'b1, 1127, 1'b1, 1, "R8");    // activate=1 encoding

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule